// File: doc/BRIEF.md
# EDO DRAM Strobe Decoder

This block stands on the device side of an asynchronous extended-data-out DRAM interface and emulates the memory behind it with logic clocked by a much faster system clock. It samples the active-low row strobe, the two byte-lane column strobes, the write strobe and the output-enable line. It takes the row and column from a shared address bus and sorts every strobe sequence into a cycle class. The classes are single read or write, page-mode read or write, read-modify-write, RAS-only refresh, CAS-before-RAS refresh and hidden refresh.

Reads and writes go to an internal synchronous array with one write enable per byte lane. The decoder also sets which byte lanes drive the data bus. The output follows EDO rules: read data stays on the bus after the column strobe rises. It changes only at the next column strobe fall, or when standby, a high output enable or a low write strobe takes the bus off. Refresh cycles report which row they would refresh. A CAS-before-RAS or hidden refresh takes the row from an internal counter.

Top module: `edo_strobe_decoder`

## Requirements
- R1: After reset, dq_oe is 00, dq_out is zero, cyc_kind is 0 (idle) and ref_pulse is low. Whenever the row strobe and both column strobes are high (standby), dq_oe returns to 00.
- R2: A row strobe fall with both column strobes high latches the row from addr. If the row strobe then rises with no column strobe fall in between, cyc_kind becomes 6 (RAS-only refresh), ref_pulse is high for one cycle and ref_row holds that row. The refresh counter does not change.
- R3: A row strobe fall while at least one column strobe is low, with no read data held, gives cyc_kind 7 (CAS-before-RAS refresh). ref_pulse is high for one cycle and ref_row equals the internal counter, which starts at 0 after reset and then advances by one modulo 256. A refresh writes nothing to the array and drives no lane.
- R4: The first column strobe fall in a row cycle with the write strobe high is a read (cyc_kind 1). It returns the word at the latched row and current column. dq_oe bit 1 (dq_out[15:8], upper strobe) and bit 0 (dq_out[7:0], lower strobe) are set only for lanes whose column strobe is low and only while output enable is low. Lanes that are not driven read zero on dq_out.
- R5: A column strobe fall with the write strobe low writes dq_in into those byte lanes whose column strobe is low (cyc_kind 2) and leaves the other byte unchanged. While the write strobe is low, no lane drives.
- R6: Every further column strobe fall in the same row cycle re-latches the column and is classified as page read (4) or page write (5).
- R7: Read data and lane enables stay unchanged after the column strobes rise, as long as the row strobe stays low. Output enable high turns all lanes off, and output enable low again restores the held lanes.
- R8: A row strobe rise and fall while a column strobe stays low after a read is a hidden refresh (cyc_kind 8). It uses and advances the refresh counter like R3, and the held read data stays on the bus.
- R9: The write strobe falling while a column strobe is still low after a read or write in the same row cycle writes dq_in to the latched row and column in the active lanes. This is a read-modify-write (cyc_kind 3), and all lanes turn off.
- R10: Every strobe input passes through a two-stage synchroniser, so an output reacts at the third rising clock edge after the strobe change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the strobes |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low, asynchronous |
| ucas_n | input | 1 | Upper-lane column strobe, active low |
| lcas_n | input | 1 | Lower-lane column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | 16 | Write data from the bus |
| dq_out | output | 16 | Read data, zero on lanes not driven |
| dq_oe | output | 2 | Per-lane drive enable (bit 1 upper, bit 0 lower) |
| cyc_kind | output | 4 | Class of the most recent decoded cycle |
| ref_pulse | output | 1 | One-cycle strobe when a refresh is performed |
| ref_row | output | REF_W | Row refreshed by the last refresh |

## Verification
The assertions assume that addr and dq_in are stable from the strobe change until three clock cycles after it, because the decoder samples them raw at the edge it detects through the synchroniser. They also assume that each strobe level lasts at least three system clocks, so no edge is lost. The stimulus changes all strobes together only at falling clock edges. It then holds every pattern, with addr and dq_in unchanged, for three full cycles before the next change. Reads only target locations that were written earlier in the same run.

// File: rtl/eds_pkg.sv
package eds_pkg;

    localparam int LANES  = 2;
    localparam int LANE_W = 8;
    localparam int DQ_W   = LANES * LANE_W;

    typedef struct packed {
        logic ras;
        logic ucas;
        logic lcas;
        logic we;
        logic oe;
    } strobe_t;

    typedef enum logic [3:0] {
        KIND_IDLE   = 4'd0,
        KIND_READ   = 4'd1,
        KIND_WRITE  = 4'd2,
        KIND_RMW    = 4'd3,
        KIND_PREAD  = 4'd4,
        KIND_PWRITE = 4'd5,
        KIND_ROR    = 4'd6,
        KIND_CBR    = 4'd7,
        KIND_HIDDEN = 4'd8
    } cyc_kind_e;

    typedef enum logic [1:0] {
        MODE_IDLE,
        MODE_ROW,
        MODE_REF
    } mode_e;

    function automatic logic [LANES-1:0] lanes_low(strobe_t s);
        return ~{s.ucas, s.lcas};
    endfunction

endpackage

// File: rtl/eds_sync.sv
module eds_sync #(
    parameter int             W      = 5,
    parameter int             STAGES = 2,
    parameter logic [W-1:0]   INIT   = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prv
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) st[i] <= INIT;
            prv <= INIT;
        end else begin
            st[0] <= din;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
            prv <= st[STAGES-1];
        end
    end

    assign cur = st[STAGES-1];
endmodule

// File: rtl/eds_array.sv
module eds_array
    import eds_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic             clk,
    input  logic [LANES-1:0] we,
    input  logic [AW-1:0]    waddr,
    input  logic [DQ_W-1:0]  wdata,
    input  logic [AW-1:0]    raddr,
    output logic [DQ_W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];
        always_ff @(posedge clk) begin
            if (we[g]) bank[waddr] <= wdata[g*LANE_W +: LANE_W];
        end
        assign rdata[g*LANE_W +: LANE_W] = bank[raddr];
    end
endmodule

// File: rtl/eds_ctrl.sv
module eds_ctrl
    import eds_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int REF_W  = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  strobe_t             cur,
    input  strobe_t             prv,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DQ_W-1:0]     dq_in,
    input  logic [DQ_W-1:0]     rdata,
    output logic [2*ADDR_W-1:0] raddr,
    output logic [2*ADDR_W-1:0] waddr,
    output logic [LANES-1:0]    mem_we,
    output logic [DQ_W-1:0]     wdata,
    output logic [DQ_W-1:0]     dq_out,
    output logic [LANES-1:0]    dq_oe,
    output logic [3:0]          kind,
    output logic                ref_pulse,
    output logic [REF_W-1:0]    ref_row
);
    mode_e             mode_q, mode_n;
    logic [ADDR_W-1:0] row_q, row_n, col_q, col_n;
    logic              acc_q, acc_n;
    logic [REF_W-1:0]  cnt_q, cnt_n, rrow_q, rrow_n;
    logic [LANES-1:0]  drv_q, drv_n, oe_q, oe_n;
    logic [DQ_W-1:0]   dout_q, dout_n, out_q, out_n;
    cyc_kind_e         kind_q, kind_n;
    logic              refp_q, refp_n;

    logic [LANES-1:0]  cas_low, cas_fall;
    logic              ras_fall, ras_rise, we_fall, standby;

    always_comb begin
        cas_low  = lanes_low(cur);
        cas_fall = cas_low & {prv.ucas, prv.lcas};
        ras_fall = !cur.ras && prv.ras;
        ras_rise = cur.ras && !prv.ras;
        we_fall  = !cur.we && prv.we && !prv.oe | !cur.we && prv.we;
        standby  = cur.ras && (cas_low == '0);
    end

    assign raddr = {row_q, addr};
    assign wdata = dq_in;

    always_comb begin
        mode_n = mode_q;  row_n = row_q;   col_n = col_q;
        acc_n  = acc_q;   cnt_n = cnt_q;   rrow_n = rrow_q;
        drv_n  = drv_q;   dout_n = dout_q; kind_n = kind_q;
        refp_n = 1'b0;
        mem_we = '0;
        waddr  = {row_q, col_q};

        if (ras_fall) begin
            if (cas_low != '0) begin
                mode_n = MODE_REF;
                refp_n = 1'b1;
                rrow_n = cnt_q;
                cnt_n  = cnt_q + 1'b1;
                kind_n = (drv_q != '0) ? KIND_HIDDEN : KIND_CBR;
            end else begin
                mode_n = MODE_ROW;
                row_n  = addr;
                acc_n  = 1'b0;
            end
        end else if (ras_rise) begin
            if (mode_q == MODE_ROW && !acc_q) begin
                kind_n = KIND_ROR;
                refp_n = 1'b1;
                rrow_n = REF_W'(row_q);
            end
            mode_n = MODE_IDLE;
        end else if (mode_q == MODE_ROW && cas_fall != '0) begin
            col_n = addr;
            acc_n = 1'b1;
            if (!cur.we) begin
                mem_we = cas_low;
                waddr  = {row_q, addr};
                kind_n = acc_q ? KIND_PWRITE : KIND_WRITE;
            end else begin
                dout_n = rdata;
                drv_n  = cas_low;
                kind_n = acc_q ? KIND_PREAD : KIND_READ;
            end
        end else if (mode_q == MODE_ROW && we_fall && acc_q && cas_low != '0) begin
            mem_we = cas_low;
            kind_n = KIND_RMW;
        end

        if (!cur.we || standby) drv_n = '0;

        oe_n = drv_n & {LANES{!cur.oe}};
        for (int g = 0; g < LANES; g++)
            out_n[g*LANE_W +: LANE_W] = oe_n[g] ? dout_n[g*LANE_W +: LANE_W] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_IDLE; row_q <= '0; col_q <= '0; acc_q <= 1'b0;
            cnt_q  <= '0; rrow_q <= '0; drv_q <= '0; dout_q <= '0;
            kind_q <= KIND_IDLE; refp_q <= 1'b0; oe_q <= '0; out_q <= '0;
        end else begin
            mode_q <= mode_n; row_q <= row_n; col_q <= col_n; acc_q <= acc_n;
            cnt_q  <= cnt_n;  rrow_q <= rrow_n; drv_q <= drv_n; dout_q <= dout_n;
            kind_q <= kind_n; refp_q <= refp_n; oe_q <= oe_n; out_q <= out_n;
        end
    end

    assign dq_out    = out_q;
    assign dq_oe     = oe_q;
    assign kind      = kind_q;
    assign ref_pulse = refp_q;
    assign ref_row   = rrow_q;
endmodule

// File: rtl/edo_strobe_decoder.sv
module edo_strobe_decoder
    import eds_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int REF_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ras_n,
    input  logic              ucas_n,
    input  logic              lcas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       dq_in,
    output logic [15:0]       dq_out,
    output logic [1:0]        dq_oe,
    output logic [3:0]        cyc_kind,
    output logic              ref_pulse,
    output logic [REF_W-1:0]  ref_row
);
    localparam int AW = 2 * ADDR_W;
    localparam int SW = $bits(strobe_t);

    strobe_t          s_raw, s_cur, s_prv;
    logic [SW-1:0]    cur_bits, prv_bits;
    logic [AW-1:0]    raddr, waddr;
    logic [LANES-1:0] mem_we;
    logic [DQ_W-1:0]  wdata, rdata;

    assign s_raw = '{ras: ras_n, ucas: ucas_n, lcas: lcas_n, we: we_n, oe: oe_n};

    eds_sync #(.W(SW), .STAGES(2), .INIT('1)) i_sync (
        .clk(clk), .rst(rst), .din(s_raw), .cur(cur_bits), .prv(prv_bits)
    );

    assign s_cur = strobe_t'(cur_bits);
    assign s_prv = strobe_t'(prv_bits);

    eds_ctrl #(.ADDR_W(ADDR_W), .REF_W(REF_W)) i_ctrl (
        .clk(clk), .rst(rst), .cur(s_cur), .prv(s_prv), .addr(addr),
        .dq_in(dq_in), .rdata(rdata), .raddr(raddr), .waddr(waddr),
        .mem_we(mem_we), .wdata(wdata), .dq_out(dq_out), .dq_oe(dq_oe),
        .kind(cyc_kind), .ref_pulse(ref_pulse), .ref_row(ref_row)
    );

    eds_array #(.AW(AW)) i_array (
        .clk(clk), .we(mem_we), .waddr(waddr), .wdata(wdata),
        .raddr(raddr), .rdata(rdata)
    );
endmodule

// File: rtl/eds_checker.sv
module eds_checker
    import eds_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input strobe_t          cur,
    input strobe_t          prv,
    input logic [LANES-1:0] mem_we,
    input logic [LANES-1:0] dq_oe,
    input logic             ref_pulse
);
    AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (rst)
        (cur.ras && cur.ucas && cur.lcas) |=> (dq_oe == '0)); // R1

    AST_OE_HIGH_HIZ: assert property (@(posedge clk) disable iff (rst)
        cur.oe |=> (dq_oe == '0)); // R7

    AST_WE_LOW_HIZ: assert property (@(posedge clk) disable iff (rst)
        !cur.we |=> (dq_oe == '0)); // R5

    AST_WRITE_ACTIVE_LANES: assert property (@(posedge clk) disable iff (rst)
        (mem_we != '0) |-> ((mem_we & {cur.ucas, cur.lcas}) == '0)); // R5

    AST_REFRESH_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!cur.ras && prv.ras && !(cur.ucas && cur.lcas)) |-> (mem_we == '0)); // R3

    AST_REF_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ref_pulse |=> !ref_pulse); // R2

    AST_REF_NEEDS_RAS_EDGE: assert property (@(posedge clk) disable iff (rst)
        $rose(ref_pulse) |-> (cur.ras != prv.ras || $past(cur.ras) != $past(prv.ras))); // R2
endmodule

bind edo_strobe_decoder eds_checker i_chk (
    .clk(clk), .rst(rst), .cur(s_cur), .prv(s_prv),
    .mem_we(mem_we), .dq_oe(dq_oe), .ref_pulse(ref_pulse)
);

// File: tb/test_edo_strobe_decoder.sv
module test_edo_strobe_decoder;
    localparam int CLK_P = 10;
    localparam int AW    = 4;
    localparam int RW    = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ras_n = 1'b1, ucas_n = 1'b1, lcas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0]   dq_in = '0;
    logic [15:0]   dq_out;
    logic [1:0]    dq_oe;
    logic [3:0]    cyc_kind;
    logic          ref_pulse;
    logic [RW-1:0] ref_row;

    int    n_run = 0, n_fail = 0;
    bit    live = 1'b0, done = 1'b0;
    string cur_req = "R1";

    always #(CLK_P/2) clk = ~clk;

    edo_strobe_decoder #(.ADDR_W(AW), .REF_W(RW)) i_edo_strobe_decoder (
        .clk(clk), .rst(rst), .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n),
        .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
        .dq_oe(dq_oe), .cyc_kind(cyc_kind), .ref_pulse(ref_pulse), .ref_row(ref_row)
    );

    // ---------------- behavioural reference model ----------------
    bit [4:0]    h1, h2, h3;           // {ras,ucas,lcas,we,oe} history
    int          m_mode, m_row, m_col, m_cnt, m_kind, m_rrow;
    bit          m_acc, m_refp;
    bit [1:0]    m_drv, m_oe;
    logic [15:0] m_dout, m_out;
    logic [15:0] m_mem [int];

    always @(posedge clk) begin
        if (rst) begin
            h1 = '1; h2 = '1; h3 = '1;
            m_mode = 0; m_row = 0; m_col = 0; m_cnt = 0; m_kind = 0; m_rrow = 0;
            m_acc = 0; m_refp = 0; m_drv = 0; m_oe = 0; m_dout = 0; m_out = 0;
        end else begin
            bit [1:0] low, was_hi;
            int a;
            low    = ~{h2[3], h2[2]};
            was_hi = {h3[3], h3[2]};
            m_refp = 0;
            if (!h2[4] && h3[4]) begin
                if (low != 0) begin
                    m_mode = 2; m_refp = 1; m_rrow = m_cnt; m_cnt = (m_cnt + 1) % 256;
                    m_kind = (m_drv != 0) ? 8 : 7;
                end else begin
                    m_mode = 1; m_row = addr; m_acc = 0;
                end
            end else if (h2[4] && !h3[4]) begin
                if (m_mode == 1 && !m_acc) begin
                    m_kind = 6; m_refp = 1; m_rrow = m_row;
                end
                m_mode = 0;
            end else if (m_mode == 1 && (low & was_hi) != 0) begin
                m_col = addr;
                a = m_row * 16 + addr;
                if (!h2[1]) begin
                    if (!m_mem.exists(a)) m_mem[a] = 16'h0000;
                    if (low[1]) m_mem[a][15:8] = dq_in[15:8];
                    if (low[0]) m_mem[a][7:0]  = dq_in[7:0];
                    m_kind = m_acc ? 5 : 2;
                end else begin
                    m_dout = m_mem.exists(a) ? m_mem[a] : 16'h0000;
                    m_drv  = low;
                    m_kind = m_acc ? 4 : 1;
                end
                m_acc = 1;
            end else if (m_mode == 1 && !h2[1] && h3[1] && m_acc && low != 0) begin
                a = m_row * 16 + m_col;
                if (low[1]) m_mem[a][15:8] = dq_in[15:8];
                if (low[0]) m_mem[a][7:0]  = dq_in[7:0];
                m_kind = 3;
            end
            if (!h2[1] || (h2[4] && low == 0)) m_drv = 0;
            m_oe  = h2[0] ? 2'b00 : m_drv;
            m_out = {m_oe[1] ? m_dout[15:8] : 8'h00, m_oe[0] ? m_dout[7:0] : 8'h00};
            h3 = h2; h2 = h1; h1 = {ras_n, ucas_n, lcas_n, we_n, oe_n};
        end
    end

    always @(negedge clk) begin
        if (live && !done) begin
            n_run++;
            if ({dq_oe, dq_out, cyc_kind, ref_pulse, ref_row} !==
                {m_oe, m_out, 4'(m_kind), m_refp, 8'(m_rrow)}) begin
                n_fail++;
                $display("FAIL %s model: act oe=%b out=%h kind=%0d refp=%b row=%0d exp oe=%b out=%h kind=%0d refp=%b row=%0d",
                         cur_req, dq_oe, dq_out, cyc_kind, ref_pulse, ref_row,
                         m_oe, m_out, m_kind, m_refp, m_rrow);
            end
        end
    end

    // ---------------- directed checks ----------------
    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic act(bit r, bit u, bit l, bit w, bit o);
        ras_n = r; ucas_n = u; lcas_n = l; we_n = w; oe_n = o;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        live = 1'b1;

        // R1 reset state
        chk("R1", "reset oe", 32'(dq_oe), 32'h0);
        chk("R1", "reset out", 32'(dq_out), 32'h0);
        chk("R1", "reset kind", 32'(cyc_kind), 32'd0);
        chk("R1", "reset refp", 32'(ref_pulse), 32'd0);

        // R5 word write row 3 col 5
        cur_req = "R5";
        addr = 3; act(0,1,1,1,0);
        addr = 5; dq_in = 16'hA55A; act(0,0,0,0,0);
        chk("R5", "write kind", 32'(cyc_kind), 32'd2);
        chk("R5", "write no drive", 32'(dq_oe), 32'h0);
        act(0,1,1,0,0); act(1,1,1,1,0);

        // R10 latency, R4 read, R7 hold
        cur_req = "R10";
        addr = 3; act(0,1,1,1,0);
        addr = 5;
        ras_n = 0; ucas_n = 0; lcas_n = 0; we_n = 1; oe_n = 0;
        repeat (2) @(negedge clk);
        chk("R10", "oe before third edge", 32'(dq_oe), 32'h0);
        @(negedge clk);
        chk("R10", "oe at third edge", 32'(dq_oe), 32'h3);
        cur_req = "R4";
        chk("R4", "read kind", 32'(cyc_kind), 32'd1);
        chk("R4", "read data", 32'(dq_out), 32'hA55A);
        cur_req = "R7";
        act(0,1,1,1,0);
        chk("R7", "hold oe after CAS rise", 32'(dq_oe), 32'h3);
        chk("R7", "hold data after CAS rise", 32'(dq_out), 32'hA55A);
        act(0,1,1,1,1);
        chk("R7", "OE high releases", 32'(dq_oe), 32'h0);
        act(0,1,1,1,0);
        chk("R7", "OE low restores", 32'(dq_oe), 32'h3);
        cur_req = "R1";
        act(1,1,1,1,0);
        chk("R1", "standby releases", 32'(dq_oe), 32'h0);

        // R5 byte write, R4 byte read, R6 page read
        cur_req = "R5";
        addr = 3; act(0,1,1,1,0);
        addr = 5; dq_in = 16'h1234; act(0,0,1,0,0);
        chk("R5", "upper byte write kind", 32'(cyc_kind), 32'd2);
        act(0,1,1,0,0); act(0,1,1,1,0);
        cur_req = "R4";
        act(0,1,0,1,0);
        chk("R4", "lower lane only oe", 32'(dq_oe), 32'h1);
        chk("R4", "lower byte unchanged", 32'(dq_out), 32'h005A);
        act(0,1,1,1,0);
        cur_req = "R6";
        act(0,0,1,1,0);
        chk("R6", "page read kind", 32'(cyc_kind), 32'd4);
        chk("R6", "upper lane data", 32'(dq_out), 32'h1200);
        chk("R6", "upper lane oe", 32'(dq_oe), 32'h2);
        act(0,1,1,1,0); act(1,1,1,1,0);

        // R6 page write then page reads at two columns
        addr = 2; act(0,1,1,1,0);
        addr = 0; dq_in = 16'h1111; act(0,0,0,0,0);
        act(0,1,1,0,0);
        addr = 1; dq_in = 16'h2222; act(0,0,0,0,0);
        chk("R6", "page write kind", 32'(cyc_kind), 32'd5);
        act(0,1,1,1,0);
        addr = 0; act(0,0,0,1,0);
        chk("R6", "col 0 data", 32'(dq_out), 32'h1111);
        act(0,1,1,1,0);
        addr = 1; act(0,0,0,1,0);
        chk("R6", "col 1 data", 32'(dq_out), 32'h2222);
        act(0,1,1,1,0); act(1,1,1,1,0);

        // R2 RAS-only refresh
        cur_req = "R2";
        addr = 9; act(0,1,1,1,0);
        act(1,1,1,1,0);
        chk("R2", "ror kind", 32'(cyc_kind), 32'd6);
        chk("R2", "ror pulse", 32'(ref_pulse), 32'd1);
        chk("R2", "ror row", 32'(ref_row), 32'd9);

        // R3 CAS-before-RAS refresh
        cur_req = "R3";
        act(1,1,0,1,0); act(0,1,0,1,0);
        chk("R3", "cbr kind", 32'(cyc_kind), 32'd7);
        chk("R3", "cbr row first", 32'(ref_row), 32'd0);
        chk("R3", "cbr no drive", 32'(dq_oe), 32'h0);
        act(1,1,0,1,0); act(1,1,1,1,0);
        act(1,0,0,1,0); act(0,0,0,1,0);
        chk("R3", "cbr row second", 32'(ref_row), 32'd1);
        act(1,1,1,1,0);

        // R8 hidden refresh
        cur_req = "R8";
        addr = 3; act(0,1,1,1,0);
        addr = 5; act(0,0,0,1,0);
        act(1,0,0,1,0);
        chk("R8", "data kept at RAS rise", 32'(dq_oe), 32'h3);
        act(0,0,0,1,0);
        chk("R8", "hidden kind", 32'(cyc_kind), 32'd8);
        chk("R8", "hidden row", 32'(ref_row), 32'd2);
        chk("R8", "hidden data kept", 32'(dq_out), 32'h125A);
        chk("R8", "hidden oe kept", 32'(dq_oe), 32'h3);
        act(1,0,0,1,0); act(1,1,1,1,0);

        // R9 read-modify-write
        cur_req = "R9";
        addr = 4; act(0,1,1,1,0);
        addr = 7; dq_in = 16'hBEEF; act(0,0,0,0,0);
        act(0,1,1,0,0); act(0,1,1,1,0);
        act(0,0,0,1,0);
        chk("R9", "read before modify", 32'(dq_out), 32'hBEEF);
        dq_in = 16'hCAFE; act(0,0,0,0,0);
        chk("R9", "rmw kind", 32'(cyc_kind), 32'd3);
        chk("R9", "rmw releases", 32'(dq_oe), 32'h0);
        act(0,1,1,0,0); act(0,1,1,1,0);
        act(0,0,0,1,0);
        chk("R9", "modified word", 32'(dq_out), 32'hCAFE);
        act(0,1,1,1,0); act(1,1,1,1,0);

        // R3 counter wraparound
        cur_req = "R3";
        for (int i = 0; i < 256; i++) begin
            act(1,0,0,1,0); act(0,0,0,1,0);
            chk("R3", "counter sequence", 32'(ref_row), 32'((3 + i) % 256));
            act(1,1,1,1,0);
        end

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule